// File: doc/BRIEF.md
# Atomic Register-Memory Exchange Sequencer

This block carries out one indivisible word exchange between a register value and a memory location. A request brings a 32-bit instruction word, the already-read address operand and the value to be stored. The block checks the fixed encoding bits and the three register fields. It then issues a read of the word-aligned address and a write of the store value to that same address, each with its own valid/ready handshake. Finally it presents the old memory word on a write-back port for the destination register.

A lock output covers the whole bus sequence, from the start of the read until the write is accepted. Other masters and interrupts use it to stay out. Misaligned addresses are handled in one of two ways, chosen by a mode input. Without translation, the loaded word is rotated right by eight bits per low address unit. With translation, the request ends in a one-cycle alignment fault and makes no access.

Top module: `xchg_seq`

## Requirements
- R1: A request is recognised only when instruction bits 27:20 equal 8'b00010000 and bits 11:4 equal 8'b00001001. Any other pattern raises `illegal` for exactly one cycle, in the cycle after the request, and makes no memory access.
- R2: A well-formed instruction with the value 15 in any register field is rejected in the same way as in R1. The fields are bits 19:16 (address), 15:12 (destination) and 3:0 (store value).
- R3: A request is ignored with no visible effect in two cases: when `req_cond_ok` is low, and when it arrives while `busy` is high.
- R4: An accepted request first reads the address with bits 1:0 cleared (`mem_write` low). After that read is accepted, it writes the store value captured with the request to the same address (`mem_write` high).
- R5: `lock` and `busy` are high from the first cycle of the read until the cycle in which the write is accepted. `lock` is low whenever no access is pending.
- R6: Each access holds `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` steady until `mem_ready` is seen, so any number of wait states is allowed.
- R7: In the cycle after the write is accepted, `wb_en` and `done` are high for one cycle. In that cycle `wb_idx` equals instruction bits 15:12 and `wb_data` equals the old word.
- R8: When the destination field equals the store-value field, the exchange is still true: memory receives the old register value and write-back carries the old memory value.
- R9: With `mmu_mode` low and address bits 1:0 nonzero, the old word is rotated right by 8 × addr[1:0] bits before write-back.
- R10: With `mmu_mode` high and address bits 1:0 nonzero, `align_fault` pulses for one cycle in the cycle after the request. No read, no write, no lock and no write-back follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exchange request strobe |
| req_insn | input | 32 | Instruction word |
| req_cond_ok | input | 1 | Condition passed (evaluated outside) |
| req_addr | input | 32 | Address operand |
| req_data | input | 32 | Value to store |
| mmu_mode | input | 1 | 1: misaligned faults, 0: misaligned rotates |
| busy | output | 1 | Sequence in progress |
| lock | output | 1 | Bus lock / interrupt inhibit |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned access address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the current access |
| mem_rdata | input | 32 | Read data, valid when the read is accepted |
| wb_en | output | 1 | Write-back strobe |
| wb_idx | output | 4 | Destination register index |
| wb_data | output | 32 | Old memory word |
| done | output | 1 | Sequence completed |
| illegal | output | 1 | Encoding or register-field rejection |
| align_fault | output | 1 | Misaligned address in translation mode |

## Verification
The hardest case to reach from the ports is a foreign request arriving in the middle of a locked sequence while the bus stretches the read or the write with wait states. To get there, the stimulus drives a second, differently-shaped request part-way through an exchange while the memory model holds back `mem_ready` at random. A reference model then confirms that neither the access stream nor the write-back changes. Same-register exchanges and all three misaligned offsets are run in both modes, so the rotation and the fault path are each seen against known memory contents.

// File: rtl/xchg_seq.sv
module xchg_seq #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   req_insn,
  input  logic          req_cond_ok,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          mmu_mode,
  output logic          busy,
  output logic          lock,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_en,
  output logic [3:0]    wb_idx,
  output logic [DW-1:0] wb_data,
  output logic          done,
  output logic          illegal,
  output logic          align_fault
);
  localparam int SHW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WRITE, S_WB, S_FAULT} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] store_q, old_q;
  logic [3:0]    dst_q;
  logic [1:0]    ofs_q;
  logic          ill_q;

  wire fmt_ok  = (req_insn[27:20] == 8'b0001_0000) && (req_insn[11:4] == 8'b0000_1001);
  wire regs_ok = (req_insn[19:16] != 4'hF) && (req_insn[15:12] != 4'hF) && (req_insn[3:0] != 4'hF);
  wire take    = req_valid && req_cond_ok && (st == S_IDLE);
  wire misal   = req_addr[1:0] != 2'b00;

  logic [SHW-1:0]  rot_amt;
  logic [2*DW-1:0] rot_dbl;
  assign rot_amt = SHW'({ofs_q, 3'b000});
  assign rot_dbl = {mem_rdata, mem_rdata} >> rot_amt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ill_q   <= 1'b0;
      addr_q  <= '0;
      store_q <= '0;
      old_q   <= '0;
      dst_q   <= '0;
      ofs_q   <= '0;
    end else begin
      ill_q <= take && !(fmt_ok && regs_ok);
      unique case (st)
        S_IDLE:
          if (take && fmt_ok && regs_ok) begin
            if (mmu_mode && misal) st <= S_FAULT;
            else begin
              st      <= S_READ;
              addr_q  <= {req_addr[AW-1:2], 2'b00};
              ofs_q   <= req_addr[1:0];
              store_q <= req_data;
              dst_q   <= req_insn[15:12];
            end
          end
        S_READ:
          if (mem_ready) begin
            old_q <= rot_dbl[DW-1:0];
            st    <= S_WRITE;
          end
        S_WRITE: if (mem_ready) st <= S_WB;
        S_WB:    st <= S_IDLE;
        S_FAULT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = st != S_IDLE;
  assign mem_valid   = (st == S_READ) || (st == S_WRITE);
  assign lock        = mem_valid;
  assign mem_write   = st == S_WRITE;
  assign mem_addr    = addr_q;
  assign mem_wdata   = store_q;
  assign wb_en       = st == S_WB;
  assign done        = st == S_WB;
  assign wb_idx      = dst_q;
  assign wb_data     = old_q;
  assign illegal     = ill_q;
  assign align_fault = st == S_FAULT;

  // R1
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !mem_valid);
  // R4
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_write) |-> $past(mem_valid && !mem_write && mem_ready));
  // R4
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
  // R5
  lock_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> lock && busy);
  // R6
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write) && $stable(mem_addr) && $stable(mem_wdata));
  // R7
  wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);
  // R7
  wb_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_en) |-> $past(mem_valid && mem_write && mem_ready));
  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !mem_valid && !wb_en && !lock);
endmodule

// File: tb/sim_xchg_seq.sv
module sim_xchg_seq;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_cond_ok = 0, mmu_mode = 0, mem_ready = 0;
  logic [31:0] req_insn = 0, req_addr = 0, req_data = 0, mem_rdata;
  logic busy, lock, mem_valid, mem_write, wb_en, done, illegal, align_fault;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [3:0] wb_idx;

  xchg_seq u0 (.clk, .rst_n, .req_valid, .req_insn, .req_cond_ok, .req_addr, .req_data,
    .mmu_mode, .busy, .lock, .mem_valid, .mem_write, .mem_addr, .mem_wdata, .mem_ready,
    .mem_rdata, .wb_en, .wb_idx, .wb_data, .done, .illegal, .align_fault);

  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  assign mem_rdata = mem[mem_addr[5:2]];
  always @(posedge clk) if (mem_valid && mem_write && mem_ready) mem[mem_addr[5:2]] <= mem_wdata;

  int checks = 0, fails = 0, cyc = 0;
  bit slow = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rotr(input logic [31:0] w, input int s);
    return (w >> s) | (w << (32 - s));
  endfunction

  function automatic bit legal(input logic [31:0] i);
    return i[27:22] == 6'b000100 && i[21:20] == 2'b00 && i[11:8] == 4'h0 && i[7:4] == 4'h9
        && i[19:16] != 15 && i[15:12] != 15 && i[3:0] != 15;
  endfunction

  // reference model
  int ph = 0;
  bit e_ill = 0;
  logic [31:0] m_addr = 0, m_st = 0, m_old = 0;
  logic [3:0] m_dst = 0;
  int m_rot = 0;
  always @(posedge clk) begin
    if (!rst_n) begin ph <= 0; e_ill <= 0; end
    else begin
      e_ill <= 0;
      case (ph)
        0: if (req_valid && req_cond_ok) begin
             if (!legal(req_insn)) e_ill <= 1;
             else if (mmu_mode && req_addr[1:0] != 0) ph <= 4;
             else begin
               ph <= 1; m_addr <= req_addr & ~32'd3; m_rot <= 8 * req_addr[1:0];
               m_st <= req_data; m_dst <= req_insn[15:12];
             end
           end
        1: if (mem_ready) begin m_old <= rotr(shadow[m_addr[5:2]], m_rot); ph <= 2; end
        2: if (mem_ready) begin shadow[m_addr[5:2]] <= m_st; ph <= 3; end
        default: ph <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    mem_ready <= slow ? ($urandom % 3 == 0) : 1'b1;
    cyc++;
    chk(busy == (ph != 0), "R5 busy", 32'(busy), 32'(ph != 0));
    chk(lock == (ph == 1 || ph == 2), "R5 lock", 32'(lock), 32'(ph == 1 || ph == 2));
    chk(mem_valid == (ph == 1 || ph == 2), "R4 mem_valid", 32'(mem_valid), 32'(ph == 1 || ph == 2));
    chk(mem_write == (ph == 2), "R4 mem_write", 32'(mem_write), 32'(ph == 2));
    if (mem_valid) chk(mem_addr == m_addr, "R4 mem_addr", mem_addr, m_addr);
    if (mem_valid && mem_write) chk(mem_wdata == m_st, "R8 mem_wdata", mem_wdata, m_st);
    chk(wb_en == (ph == 3) && done == (ph == 3), "R7 wb_en/done", {wb_en, done}, 32'(ph == 3));
    if (ph == 3) begin
      chk(wb_idx == m_dst, "R7 wb_idx", 32'(wb_idx), 32'(m_dst));
      chk(wb_data == m_old, "R9 wb_data", wb_data, m_old);
    end
    chk(illegal == e_ill, "R1 R2 illegal", 32'(illegal), 32'(e_ill));
    chk(align_fault == (ph == 4), "R10 align_fault", 32'(align_fault), 32'(ph == 4));
    for (int i = 0; i < 16; i++)
      if (mem[i] !== shadow[i]) chk(0, "R4 memory", mem[i], shadow[i]);
  end

  function automatic logic [31:0] enc(input logic [3:0] ra, input logic [3:0] rd, input logic [3:0] rv);
    return {4'hE, 6'b000100, 2'b00, ra, rd, 4'h0, 4'h9, rv};
  endfunction

  task automatic op(input logic [31:0] insn, input bit cond, input logic [31:0] a,
                    input logic [31:0] d, input bit poke);
    @(negedge clk);
    req_valid = 1; req_cond_ok = cond; req_insn = insn; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      // R3: foreign request during a locked sequence
      req_valid = 1; req_cond_ok = 1; req_insn = enc(4'd1, 4'd2, 4'd3);
      req_addr = 32'h24; req_data = 32'hDEADBEEF;
      @(negedge clk);
      req_valid = 0;
    end
    while (ph != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'hA000_0000 + i * 32'h0102_0304 + 32'h0011_2233;
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(!busy && !lock && !mem_valid && !wb_en && !illegal && !align_fault, "R5 reset",
        {busy, lock, mem_valid, wb_en, illegal, align_fault}, 0);
    rst_n = 1;
    op(enc(2, 0, 1), 1, 32'h10, 32'h1111_2222, 0);          // R4 R7
    slow = 1;
    op(enc(2, 5, 6), 1, 32'h14, 32'h3333_4444, 0);          // R6
    op(enc(4, 7, 7), 1, 32'h18, 32'h5555_6666, 0);          // R8 same register
    op(enc(4, 3, 3), 1, 32'h18, 32'h7777_8888, 1);          // R8 R3 busy poke
    for (int k = 1; k < 4; k++) op(enc(1, 2, 3), 1, 32'h20 + k, 32'h1234_5670 + k, 0); // R9
    mmu_mode = 1;
    for (int k = 1; k < 4; k++) op(enc(1, 2, 3), 1, 32'h30 + k, 32'hFFFF_0000, 0);    // R10
    op(enc(1, 9, 3), 1, 32'h30, 32'h0BAD_F00D, 1);         // aligned in mmu mode
    mmu_mode = 0;
    op(enc(15, 2, 3), 1, 32'h08, 32'h1, 0);                // R2
    op(enc(1, 15, 3), 1, 32'h08, 32'h2, 0);                // R2
    op(enc(1, 2, 15), 1, 32'h08, 32'h3, 0);                // R2
    op(enc(1, 2, 3) ^ 32'h0040_0000, 1, 32'h08, 32'h4, 0); // R1 bits 27:22
    op(enc(1, 2, 3) | 32'h0010_0000, 1, 32'h08, 32'h5, 0); // R1 bits 21:20
    op(enc(1, 2, 3) | 32'h0000_0100, 1, 32'h08, 32'h6, 0); // R1 bits 11:8
    op(enc(1, 2, 3) ^ 32'h0000_0010, 1, 32'h08, 32'h7, 0); // R1 bits 7:4
    op(enc(1, 2, 3), 0, 32'h08, 32'h8, 0);                 // R3 cond fail
    for (int k = 0; k < 20; k++) op(enc(1, 4'(k % 15), 4'((k * 7) % 15)), 1, 32'(k * 4 + (k % 4)), $urandom, k[0]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule